// File: doc/BRIEF.md
# Byte Write Enable Decoder

This block turns the write-control pins of a synchronous memory into per-lane write strobes. The memory word is built from 9-bit lanes: eight data bits plus one parity bit. The default build has four lanes and a 36-bit word. A narrow build with two lanes serves an 18-bit word.

Three kinds of control are sampled on each rising clock edge: a global write, a lane-write gate and one select per lane. The global write claims every lane and wins over everything else. When the gate is closed, the lane selects are blocked. When the gate is open, each select reaches its own lane. The decoded result is held in registers and appears one cycle after the edge that sampled it. It is presented in three forms:
- a lane strobe vector;
- per-bit strobes for the 32 data bits and the 4 parity bits;
- a write-active flag.

The block also raises a flag that forces the memory's data drivers off whenever any lane is written.

Top module: `byte_write_decoder`

## Requirements
- R1: While reset is high at a rising edge, the next outputs are idle: every lane strobe, data strobe, parity strobe and the write-active flag read 1, and the output-disable flag reads 0.
- R2: A global write (gw_n = 0) at an edge selects every lane (all lane strobes 0), whatever the gate and the selects are.
- R3: With gw_n = 1 and the gate open (gate_n = 0), lane strobe k equals sel_n[k]: lane k is written exactly when sel_n[k] = 0.
- R4: With gw_n = 1 and the gate closed (gate_n = 1), no lane is written (all lane strobes 1), whatever sel_n holds.
- R5: Data strobe bit b equals lane strobe b/8, so lane k covers data bits 8k to 8k+7. Parity strobe bit k equals lane strobe k.
- R6: The write-active flag wr_act_n is 0 exactly when at least one lane strobe is 0.
- R7: out_dis is 1 exactly when at least one lane strobe is 0, so any lane write turns the data outputs off.
- R8: All outputs are registered. They show the decode of the inputs sampled at the previous rising edge. After an edge with no write they return to idle.
- R9: In a build with LANES = 2, selects sel_n[3:2] have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| gw_n | input | 1 | Global write, active low, claims every lane |
| gate_n | input | 1 | Lane-write gate, active low; when high the selects are blocked |
| sel_n | input | SEL_W (4) | Per-lane write selects, active low; bit k is lane k |
| lane_we_n | output | LANES (4) | Registered lane write strobes, active low |
| data_we_n | output | LANES*DBITS (32) | Registered per-data-bit write strobes, active low |
| par_we_n | output | LANES (4) | Registered per-parity-bit write strobes, active low |
| wr_act_n | output | 1 | Registered flag, low when any lane is written |
| out_dis | output | 1 | Registered flag, high to force the data drivers off |

## Verification
A global write and an open gate with a partial select pattern can fall in the same cycle. That cycle tests the precedence between the two write paths. The bench drives gw_n low together with gate_n low and selects that leave some lanes unselected. It expects every lane, every data and parity strobe, the active flag and the output-disable flag to show a full write on the next edge. The same patterns are then repeated with gw_n high, where exactly the selected lanes must appear.

// File: rtl/wbe_pkg.sv
package wbe_pkg;

  // Active-low write control sampled each edge.
  typedef struct packed {
    logic gw_n;
    logic gate_n;
  } wr_ctl_t;

  // Active level for strobes on the outputs.
  localparam logic STB_ON  = 1'b0;
  localparam logic STB_OFF = 1'b1;

endpackage

// File: rtl/wbe_gate.sv
module wbe_gate
  import wbe_pkg::*;
#(
  parameter int LANES = 4
) (
  input  wr_ctl_t          ctl,
  input  logic [LANES-1:0] sel_n,
  output logic [LANES-1:0] lane_hit
);

  logic [LANES-1:0] sel_pass;

  // Stage 1: the gate decides whether the selects reach the lanes.
  always_comb begin
    if (ctl.gate_n == STB_ON) sel_pass = ~sel_n;
    else                      sel_pass = '0;
  end

  // Stage 2: a global write overrides the gated selects.
  always_comb begin
    if (ctl.gw_n == STB_ON) lane_hit = '1;
    else                    lane_hit = sel_pass;
  end

endmodule

// File: rtl/wbe_expand.sv
module wbe_expand #(
  parameter int LANES = 4,
  parameter int DBITS = 8
) (
  input  logic [LANES-1:0]       lane_hit,
  output logic [LANES*DBITS-1:0] data_hit,
  output logic [LANES-1:0]       par_hit
);

  // Lane k owns data bits [k*DBITS +: DBITS] and parity bit k.
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign data_hit[k*DBITS +: DBITS] = {DBITS{lane_hit[k]}};
    assign par_hit[k]                 = lane_hit[k];
  end

endmodule

// File: rtl/byte_write_decoder.sv
module byte_write_decoder
  import wbe_pkg::*;
#(
  parameter int LANES = 4,
  parameter int SEL_W = 4,
  parameter int DBITS = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   gw_n,
  input  logic                   gate_n,
  input  logic [SEL_W-1:0]       sel_n,
  output logic [LANES-1:0]       lane_we_n,
  output logic [LANES*DBITS-1:0] data_we_n,
  output logic [LANES-1:0]       par_we_n,
  output logic                   wr_act_n,
  output logic                   out_dis
);

  localparam int WBITS = LANES * DBITS;

  wr_ctl_t          ctl;
  logic [LANES-1:0] lane_hit;
  logic [WBITS-1:0] data_hit;
  logic [LANES-1:0] par_hit;
  logic             any_hit;

  assign ctl.gw_n   = gw_n;
  assign ctl.gate_n = gate_n;

  // Selects above the built lane count are dropped.
  if (LANES < SEL_W) begin : g_narrow
    logic sel_unused;
    assign sel_unused = ^sel_n[SEL_W-1:LANES];
  end

  wbe_gate #(.LANES(LANES)) u_gate (
    .ctl      (ctl),
    .sel_n    (sel_n[LANES-1:0]),
    .lane_hit (lane_hit)
  );

  wbe_expand #(.LANES(LANES), .DBITS(DBITS)) u_expand (
    .lane_hit (lane_hit),
    .data_hit (data_hit),
    .par_hit  (par_hit)
  );

  assign any_hit = |lane_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_we_n <= '1;
      data_we_n <= '1;
      par_we_n  <= '1;
      wr_act_n  <= STB_OFF;
      out_dis   <= 1'b0;
    end else begin
      lane_we_n <= ~lane_hit;
      data_we_n <= ~data_hit;
      par_we_n  <= ~par_hit;
      wr_act_n  <= ~any_hit;
      out_dis   <= any_hit;
    end
  end

endmodule

// File: rtl/wbe_checker.sv
module wbe_checker #(
  parameter int LANES = 4,
  parameter int SEL_W = 4,
  parameter int DBITS = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   gw_n,
  input logic                   gate_n,
  input logic [SEL_W-1:0]       sel_n,
  input logic [LANES-1:0]       lane_we_n,
  input logic [LANES*DBITS-1:0] data_we_n,
  input logic [LANES-1:0]       par_we_n,
  input logic                   wr_act_n,
  input logic                   out_dis
);

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (&lane_we_n && wr_act_n && !out_dis));

  p_global_all_r2: assert property (@(posedge clk) disable iff (rst)
    !gw_n |=> (lane_we_n == '0));

  p_gate_pass_r3: assert property (@(posedge clk) disable iff (rst)
    (gw_n && !gate_n) |=> (lane_we_n == $past(sel_n[LANES-1:0])));

  p_gate_block_r4: assert property (@(posedge clk) disable iff (rst)
    (gw_n && gate_n) |=> (&lane_we_n));

  p_parity_lane_r5: assert property (@(posedge clk) disable iff (rst)
    par_we_n == lane_we_n);

  p_low_byte_r5: assert property (@(posedge clk) disable iff (rst)
    data_we_n[0] == lane_we_n[0]);

  p_active_flag_r6: assert property (@(posedge clk) disable iff (rst)
    wr_act_n == (&lane_we_n));

  p_out_off_r7: assert property (@(posedge clk) disable iff (rst)
    out_dis == !wr_act_n);

endmodule

bind byte_write_decoder wbe_checker #(
  .LANES(LANES), .SEL_W(SEL_W), .DBITS(DBITS)
) u_chk (
  .clk(clk), .rst(rst), .gw_n(gw_n), .gate_n(gate_n), .sel_n(sel_n),
  .lane_we_n(lane_we_n), .data_we_n(data_we_n), .par_we_n(par_we_n),
  .wr_act_n(wr_act_n), .out_dis(out_dis)
);

// File: tb/byte_write_decoder_test.sv
`timescale 1ns/1ps
module byte_write_decoder_test;

  localparam int CLK_NS = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       gw_n = 1'b1;
  logic       gate_n = 1'b1;
  logic [3:0] sel_n = 4'hF;

  logic [3:0]  lane_we_n;
  logic [31:0] data_we_n;
  logic [3:0]  par_we_n;
  logic        wr_act_n;
  logic        out_dis;

  logic [1:0]  n_lane_we_n;
  logic [15:0] n_data_we_n;
  logic [1:0]  n_par_we_n;
  logic        n_wr_act_n;
  logic        n_out_dis;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_NS/2) clk = ~clk;

  byte_write_decoder uut (
    .clk(clk), .rst(rst), .gw_n(gw_n), .gate_n(gate_n), .sel_n(sel_n),
    .lane_we_n(lane_we_n), .data_we_n(data_we_n), .par_we_n(par_we_n),
    .wr_act_n(wr_act_n), .out_dis(out_dis)
  );

  byte_write_decoder #(.LANES(2)) uut_narrow (
    .clk(clk), .rst(rst), .gw_n(gw_n), .gate_n(gate_n), .sel_n(sel_n),
    .lane_we_n(n_lane_we_n), .data_we_n(n_data_we_n), .par_we_n(n_par_we_n),
    .wr_act_n(n_wr_act_n), .out_dis(n_out_dis)
  );

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Drive at the falling edge, let one rising edge sample, then look.
  task automatic step(logic g, logic b, logic [3:0] s);
    gw_n = g; gate_n = b; sel_n = s;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [3:0] exp_lanes_n(logic g, logic b, logic [3:0] s);
    if (!g)      return 4'h0;
    else if (!b) return s;
    else         return 4'hF;
  endfunction

  function automatic logic [31:0] exp_data_n(logic [3:0] ln);
    logic [31:0] d;
    for (int i = 0; i < 32; i++) d[i] = ln[i/8];
    return d;
  endfunction

  task automatic check_wide(string req, logic g, logic b, logic [3:0] s);
    logic [3:0] ln;
    ln = exp_lanes_n(g, b, s);
    check({req, " lanes"}, 64'(lane_we_n), 64'(ln));
    check({req, " R5 data"}, 64'(data_we_n), 64'(exp_data_n(ln)));
    check({req, " R5 parity"}, 64'(par_we_n), 64'(ln));
    check({req, " R6 active"}, 64'(wr_act_n), 64'(&ln));
    check({req, " R7 outdis"}, 64'(out_dis), 64'(~&ln));
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step(1'b0, 1'b0, 4'h0);
    check_wide("R1", 1'b1, 1'b1, 4'hF);
    check("R1 narrow", 64'({n_lane_we_n, n_wr_act_n, n_out_dis}), 64'(4'b1110));
    rst = 1'b0;
  endtask

  task automatic t_global();
    // Precedence: global write in the same cycle as open gate, partial selects.
    step(1'b0, 1'b0, 4'b1010);
    check_wide("R2 gate open", 1'b0, 1'b0, 4'b1010);
    step(1'b0, 1'b1, 4'hF);
    check_wide("R2 gate closed", 1'b0, 1'b1, 4'hF);
    step(1'b0, 1'b0, 4'hF);
    check_wide("R2 no selects", 1'b0, 1'b0, 4'hF);
  endtask

  task automatic t_pass();
    logic [3:0] pats [5] = '{4'b1110, 4'b0111, 4'b0101, 4'b0000, 4'b1011};
    foreach (pats[i]) begin
      step(1'b1, 1'b0, pats[i]);
      check_wide("R3", 1'b1, 1'b0, pats[i]);
    end
  endtask

  task automatic t_block();
    step(1'b1, 1'b1, 4'b0000);
    check_wide("R4 all selects", 1'b1, 1'b1, 4'b0000);
    step(1'b1, 1'b1, 4'b0110);
    check_wide("R4 some selects", 1'b1, 1'b1, 4'b0110);
  endtask

  task automatic t_latency();
    step(1'b1, 1'b0, 4'b1101);
    gw_n = 1'b1; gate_n = 1'b1; sel_n = 4'hF;
    #2;
    check("R8 holds before edge", 64'(lane_we_n), 64'(4'b1101));
    @(posedge clk);
    @(negedge clk);
    check_wide("R8 back to idle", 1'b1, 1'b1, 4'hF);
  endtask

  task automatic t_narrow();
    step(1'b1, 1'b0, 4'b0011);
    check("R9 upper selects only", 64'({n_lane_we_n, n_par_we_n, n_wr_act_n, n_out_dis}),
          64'(6'b111110));
    check("R9 data", 64'(n_data_we_n), 64'(16'hFFFF));
    step(1'b1, 1'b0, 4'b1110);
    check("R9 lane0", 64'({n_lane_we_n, n_data_we_n}), 64'({2'b10, 16'hFF00}));
    step(1'b1, 1'b0, 4'b0010);
    check("R9 lane0 upper low", 64'({n_lane_we_n, n_out_dis}), 64'({2'b10, 1'b1}));
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_global();
    t_pass();
    t_block();
    t_latency();
    t_narrow();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule